// File: doc/BRIEF.md
# Interrupt Vector Fetch Unit

This unit handles entry into reset and interrupt service routines for a processor whose code addresses are split into a segment number and a 16-bit offset. When it accepts an interrupt of a given type, it reads that type's 2-byte branch target from a fixed vector area in segment 0. It does this through a byte-wide program-memory read port. It then loads the assembled target into the program counter and clears the code segment register, so every handler starts in segment 0.

When the medium memory model is selected, entry also pushes the interrupted code segment onto the stack. A later return request pops that value and writes it back into the segment register, so execution resumes in the segment that was interrupted. In the small model, entry pushes nothing and a return leaves the segment register alone. After reset is released, the unit fetches the reset vector on its own, without a request. Priority arbitration and the stacking of the program counter and flags are handled elsewhere.

Top module: `vector_entry_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, every strobe output (`mem_rd`, `stk_push`, `stk_pop`, `pc_load`, `seg_load`, `irq_ack`, `rti_ack`) is low in the following cycle.
- R2: Vector address for type t is 2·t for t in 0..22 (lower window) and 0x6A + 2·(t−23) for t in 23..27 (upper window, ending at 0x73). The first read of a fetch uses this even address in the cycle after acceptance.
- R3: The second read comes in the next cycle at the even address plus one. The memory returns the byte in the cycle after `mem_rd`. No third read follows.
- R4: `pc_load` pulses in the fourth cycle after acceptance. `pc_value` is {byte at odd address, byte at even address}, with the even address holding the low byte.
- R5: Whenever `pc_load` is high, `seg_load` is high and `seg_value` is 0.
- R6: In the medium model (`medium_model` = 1 when the request is accepted), `stk_push` pulses in the cycle before `pc_load`. `stk_wdata` then carries the `cur_seg` value sampled at acceptance. In the small model there is no push.
- R7: A return request accepted in idle in the medium model pulses `stk_pop` for one cycle. In the next cycle it raises `seg_load` and `rti_ack`, with `seg_value` equal to `stk_rdata`, which the stack presents in the cycle after the pop. In the small model, `rti_ack` comes in the cycle after acceptance, with no pop and no `seg_load`.
- R8: For an interrupt, `irq_ack` is a one-cycle pulse in the same cycle as `pc_load`.
- R9: Requests are sampled only in idle. If an interrupt and a return are both requested, the interrupt goes first. A request made while a sequence runs waits until the unit is idle again.
- R10: An interrupt request with type 28 or above is never accepted: no read, no load and no acknowledge.
- R11: In the first cycle after reset is released, the unit starts fetching type 0 on its own. This fetch pushes nothing and gives no `irq_ack`, in either memory model.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| medium_model | input | 1 | 1 selects the medium memory model, sampled at acceptance |
| irq_req | input | 1 | Interrupt request, held until `irq_ack` |
| irq_type | input | 5 | Interrupt type code |
| irq_ack | output | 1 | Interrupt entry complete |
| rti_req | input | 1 | Return-from-interrupt request, held until `rti_ack` |
| rti_ack | output | 1 | Return handling complete |
| cur_seg | input | SEG_W | Current code segment register value |
| mem_rd | output | 1 | Program-memory read strobe |
| mem_addr | output | 16 | Segment-0 read address |
| mem_data | input | 8 | Read byte, valid the cycle after `mem_rd` |
| stk_push | output | 1 | Push the saved segment |
| stk_wdata | output | SEG_W | Segment value to push |
| stk_pop | output | 1 | Pop the saved segment |
| stk_rdata | input | SEG_W | Popped value, valid the cycle after `stk_pop` |
| pc_load | output | 1 | Load the program counter |
| pc_value | output | 16 | Branch target |
| seg_load | output | 1 | Load the code segment register |
| seg_value | output | SEG_W | New segment value |

## Verification
The bench targets these corner cases:
- Types 22 and 23, at the boundary between the two windows, and type 27 at the top of the upper window. A wrong window split would fetch from the gap between the windows.
- Byte order. Swapped bytes show up as a wrong `pc_value` on every fetch.
- Returns in both models. A return in the small model must not touch the segment register, and a pop from an empty stack must still complete.
- Reset in the middle of a fetch. It must abandon the fetch and restart with the boot fetch, with no stray acknowledge or push.
- An interrupt and a return requested together. The interrupt must win, and a unit that sampled requests while busy would show extra reads or an early `rti_ack`.
- Out-of-range types. A unit that accepted them would issue reads that the per-cycle model does not expect.

// File: rtl/veu_pkg.sv
// Package: shared state encoding for the vector entry unit.
// Assumes: nothing beyond its users importing it.
package veu_pkg;
    typedef enum logic [2:0] {
        ST_BOOT,
        ST_IDLE,
        ST_RD_LO,
        ST_RD_HI,
        ST_SAVE,
        ST_LOAD,
        ST_POP,
        ST_RESTORE
    } veu_state_e;
endpackage

// File: rtl/veu_addr_map.sv
// Module: maps a type code to the even address of its vector.
// Assumes: type codes below LOW_SLOTS use the lower window; the remainder
// are packed from HIGH_BASE upward. The caller range-checks the type.
module veu_addr_map #(
    parameter int TYPE_W    = 5,
    parameter int ADDR_W    = 16,
    parameter int NUM_TYPES = 28,
    parameter int LOW_SLOTS = 23,
    parameter int HIGH_BASE = 'h6A
) (
    input  logic [TYPE_W-1:0] type_i,
    output logic [ADDR_W-1:0] base_o
);
    localparam int HIGH_SLOTS = NUM_TYPES - LOW_SLOTS;

    generate
        if (HIGH_SLOTS > 0) begin : g_split
            logic              in_low;
            logic [TYPE_W-1:0] high_idx;
            // Pick the window, then scale the index inside it by two.
            always_comb begin
                in_low   = type_i < TYPE_W'(LOW_SLOTS);
                high_idx = type_i - TYPE_W'(LOW_SLOTS);
                if (in_low)
                    base_o = ADDR_W'({type_i, 1'b0});
                else
                    base_o = ADDR_W'(HIGH_BASE) + ADDR_W'({high_idx, 1'b0});
            end
        end else begin : g_single
            // Every type fits the lower window.
            always_comb base_o = ADDR_W'({type_i, 1'b0});
        end
    endgenerate
endmodule

// File: rtl/veu_ctrl.sv
// Module: sequencing state machine for vector entry and segment return.
// Assumes: memory and stack both answer one cycle after their strobe;
// requesters hold their request until acknowledged.
module veu_ctrl
    import veu_pkg::*;
#(
    parameter int TYPE_W    = 5,
    parameter int NUM_TYPES = 28
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              medium_model,
    input  logic              irq_req,
    input  logic [TYPE_W-1:0] irq_type,
    input  logic              rti_req,
    output logic              accept_irq,
    output logic              boot_start,
    output logic              mem_rd,
    output logic              rd_hi,
    output logic              cap_lo,
    output logic              cap_hi,
    output logic              stk_push,
    output logic              stk_pop,
    output logic              pc_load,
    output logic              seg_load,
    output logic              seg_zero,
    output logic              irq_ack,
    output logic              rti_ack
);
    veu_state_e state;
    logic       boot_q;
    logic       med_q;
    logic       type_ok;

    assign type_ok    = irq_type < TYPE_W'(NUM_TYPES);
    assign accept_irq = (state == ST_IDLE) && irq_req && type_ok;
    assign boot_start = (state == ST_BOOT);

    // Advance the sequence and latch the mode flags at acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_BOOT;
            boot_q <= 1'b0;
            med_q  <= 1'b0;
        end else begin
            unique case (state)
                ST_BOOT: begin
                    state  <= ST_RD_LO;
                    boot_q <= 1'b1;
                end
                ST_IDLE: begin
                    if (irq_req && type_ok) begin
                        state  <= ST_RD_LO;
                        boot_q <= 1'b0;
                        med_q  <= medium_model;
                    end else if (rti_req) begin
                        med_q <= medium_model;
                        state <= medium_model ? ST_POP : ST_RESTORE;
                    end
                end
                ST_RD_LO:   state <= ST_RD_HI;
                ST_RD_HI:   state <= ST_SAVE;
                ST_SAVE:    state <= ST_LOAD;
                ST_LOAD:    state <= ST_IDLE;
                ST_POP:     state <= ST_RESTORE;
                ST_RESTORE: state <= ST_IDLE;
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Decode the registered state into strobes.
    always_comb begin
        mem_rd   = (state == ST_RD_LO) || (state == ST_RD_HI);
        rd_hi    = (state == ST_RD_HI);
        cap_lo   = (state == ST_RD_HI);
        cap_hi   = (state == ST_SAVE);
        stk_push = (state == ST_SAVE) && med_q && !boot_q;
        stk_pop  = (state == ST_POP);
        pc_load  = (state == ST_LOAD);
        seg_zero = (state == ST_LOAD);
        seg_load = (state == ST_LOAD) || ((state == ST_RESTORE) && med_q);
        irq_ack  = (state == ST_LOAD) && !boot_q;
        rti_ack  = (state == ST_RESTORE);
    end
endmodule

// File: rtl/veu_target_reg.sv
// Module: holds the accepted type, the interrupted segment and the two
// vector bytes while a fetch runs.
// Assumes: capture strobes come from veu_ctrl in the documented order.
module veu_target_reg #(
    parameter int TYPE_W = 5,
    parameter int SEG_W  = 2,
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                accept_irq,
    input  logic                boot_start,
    input  logic [TYPE_W-1:0]   irq_type,
    input  logic [SEG_W-1:0]    cur_seg,
    input  logic                cap_lo,
    input  logic                cap_hi,
    input  logic [DATA_W-1:0]   mem_data,
    output logic [TYPE_W-1:0]   type_q,
    output logic [SEG_W-1:0]    seg_q,
    output logic [2*DATA_W-1:0] target
);
    logic [DATA_W-1:0] lo_q;
    logic [DATA_W-1:0] hi_q;

    // Latch the request context at acceptance; boot forces type 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            type_q <= '0;
            seg_q  <= '0;
        end else if (boot_start) begin
            type_q <= '0;
            seg_q  <= '0;
        end else if (accept_irq) begin
            type_q <= irq_type;
            seg_q  <= cur_seg;
        end
    end

    // Collect the returned vector bytes, low first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= '0;
            hi_q <= '0;
        end else begin
            if (cap_lo) lo_q <= mem_data;
            if (cap_hi) hi_q <= mem_data;
        end
    end

    assign target = {hi_q, lo_q};
endmodule

// File: rtl/vector_entry_unit.sv
// Module: top of the interrupt vector fetch unit.
// Assumes: one-cycle memory and stack latency; arbitration upstream.
module vector_entry_unit #(
    parameter int NUM_TYPES = 28,
    parameter int LOW_SLOTS = 23,
    parameter int HIGH_BASE = 'h6A,
    parameter int ADDR_W    = 16,
    parameter int SEG_W     = 2,
    localparam int TYPE_W   = $clog2(NUM_TYPES),
    localparam int DATA_W   = ADDR_W / 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              medium_model,
    input  logic              irq_req,
    input  logic [TYPE_W-1:0] irq_type,
    output logic              irq_ack,
    input  logic              rti_req,
    output logic              rti_ack,
    input  logic [SEG_W-1:0]  cur_seg,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [DATA_W-1:0] mem_data,
    output logic              stk_push,
    output logic [SEG_W-1:0]  stk_wdata,
    output logic              stk_pop,
    input  logic [SEG_W-1:0]  stk_rdata,
    output logic              pc_load,
    output logic [ADDR_W-1:0] pc_value,
    output logic              seg_load,
    output logic [SEG_W-1:0]  seg_value
);
    logic              accept_irq;
    logic              boot_start;
    logic              rd_hi;
    logic              cap_lo;
    logic              cap_hi;
    logic              seg_zero;
    logic [TYPE_W-1:0] type_q;
    logic [ADDR_W-1:0] base_addr;

    veu_ctrl #(
        .TYPE_W    (TYPE_W),
        .NUM_TYPES (NUM_TYPES)
    ) u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .medium_model (medium_model),
        .irq_req      (irq_req),
        .irq_type     (irq_type),
        .rti_req      (rti_req),
        .accept_irq   (accept_irq),
        .boot_start   (boot_start),
        .mem_rd       (mem_rd),
        .rd_hi        (rd_hi),
        .cap_lo       (cap_lo),
        .cap_hi       (cap_hi),
        .stk_push     (stk_push),
        .stk_pop      (stk_pop),
        .pc_load      (pc_load),
        .seg_load     (seg_load),
        .seg_zero     (seg_zero),
        .irq_ack      (irq_ack),
        .rti_ack      (rti_ack)
    );

    veu_target_reg #(
        .TYPE_W (TYPE_W),
        .SEG_W  (SEG_W),
        .DATA_W (DATA_W)
    ) u_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .accept_irq (accept_irq),
        .boot_start (boot_start),
        .irq_type   (irq_type),
        .cur_seg    (cur_seg),
        .cap_lo     (cap_lo),
        .cap_hi     (cap_hi),
        .mem_data   (mem_data),
        .type_q     (type_q),
        .seg_q      (stk_wdata),
        .target     (pc_value)
    );

    veu_addr_map #(
        .TYPE_W    (TYPE_W),
        .ADDR_W    (ADDR_W),
        .NUM_TYPES (NUM_TYPES),
        .LOW_SLOTS (LOW_SLOTS),
        .HIGH_BASE (HIGH_BASE)
    ) u_map (
        .type_i (type_q),
        .base_o (base_addr)
    );

    // Second read of a pair targets the odd byte.
    assign mem_addr  = base_addr + ADDR_W'(rd_hi);
    // Entry clears the segment; a return restores the popped one.
    assign seg_value = seg_zero ? '0 : stk_rdata;
endmodule

// File: rtl/veu_checker.sv
// Module: temporal checks on the vector entry unit's ports.
// Assumes: bound to every vector_entry_unit instance below.
module veu_checker #(
    parameter int ADDR_W = 16,
    parameter int SEG_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              stk_push,
    input logic              stk_pop,
    input logic              pc_load,
    input logic              seg_load,
    input logic [SEG_W-1:0]  seg_value,
    input logic              irq_ack,
    input logic              rti_ack
);
    // R2
    first_read_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && !$past(mem_rd) |-> !mem_addr[0]);
    // R3
    second_read_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && $past(mem_rd) |-> mem_addr == ($past(mem_addr) + ADDR_W'(1)));
    // R3
    read_pair_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd && $past(mem_rd) |=> !mem_rd);
    // R5
    entry_seg_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> seg_load && seg_value == '0);
    // R6
    push_before_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_push |=> pc_load);
    // R7
    restore_after_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stk_pop |=> rti_ack && seg_load);
    // R8
    ack_with_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ack |-> pc_load);
    // R9
    single_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, stk_push, stk_pop, pc_load, rti_ack}));
endmodule

bind vector_entry_unit veu_checker #(
    .ADDR_W (ADDR_W),
    .SEG_W  (SEG_W)
) u_veu_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_rd    (mem_rd),
    .mem_addr  (mem_addr),
    .stk_push  (stk_push),
    .stk_pop   (stk_pop),
    .pc_load   (pc_load),
    .seg_load  (seg_load),
    .seg_value (seg_value),
    .irq_ack   (irq_ack),
    .rti_ack   (rti_ack)
);

// File: tb/vector_entry_unit_test.sv
// Bench: behavioural per-cycle model of the vector entry unit, compared
// against the design at every falling edge.
module vector_entry_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        medium_model = 1'b0;
    logic        irq_req = 1'b0;
    logic [4:0]  irq_type = '0;
    logic        irq_ack;
    logic        rti_req = 1'b0;
    logic        rti_ack;
    logic [1:0]  cur_seg = '0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_data = '0;
    logic        stk_push;
    logic [1:0]  stk_wdata;
    logic        stk_pop;
    logic [1:0]  stk_rdata = '0;
    logic        pc_load;
    logic [15:0] pc_value;
    logic        seg_load;
    logic [1:0]  seg_value;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;

    vector_entry_unit uut (
        .clk(clk), .rst_n(rst_n), .medium_model(medium_model),
        .irq_req(irq_req), .irq_type(irq_type), .irq_ack(irq_ack),
        .rti_req(rti_req), .rti_ack(rti_ack), .cur_seg(cur_seg),
        .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_data(mem_data),
        .stk_push(stk_push), .stk_wdata(stk_wdata), .stk_pop(stk_pop),
        .stk_rdata(stk_rdata), .pc_load(pc_load), .pc_value(pc_value),
        .seg_load(seg_load), .seg_value(seg_value)
    );

    always #4 clk = ~clk;

    function automatic logic [7:0] rom_byte(input int a);
        return 8'((a * 37) ^ 'hC3);
    endfunction

    function automatic int vec_of(input int t);
        return (t < 23) ? 2 * t : 'h6A + 2 * (t - 23);
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s %s actual=%0h expected=%0h @cycle %0d",
                     tag, what, act, exp, cyc);
        end
    endtask

    // Memory and stack environment, one-cycle answers.
    logic [1:0] env_stack[$];
    always @(posedge clk) begin
        cyc <= cyc + 1;
        mem_data <= mem_rd ? rom_byte(int'(mem_addr)) : 8'h00;
        if (stk_push) env_stack.push_back(stk_wdata);
        if (stk_pop) begin
            if (env_stack.size() > 0) stk_rdata <= env_stack.pop_back();
            else stk_rdata <= '0;
        end
    end

    // Reference model: phase 99 boot, 0 idle, 1..4 fetch, 10..11 return.
    int         ph = 99;
    int         mt = 0;
    bit         mres = 0;
    bit         mmed = 0;
    logic [1:0] mseg = '0;
    logic [1:0] mpop = '0;
    logic [1:0] mstack[$];
    always @(posedge clk) begin
        if (!rst_n) ph = 99;
        else begin
            case (ph)
                99: begin ph = 1; mt = 0; mres = 1; end
                0: begin
                    if (irq_req && irq_type < 28) begin
                        ph = 1; mt = int'(irq_type); mres = 0;
                        mmed = medium_model; mseg = cur_seg;
                    end else if (rti_req) begin
                        mmed = medium_model;
                        ph = medium_model ? 10 : 11;
                    end
                end
                1: ph = 2;
                2: ph = 3;
                3: begin
                    if (mmed && !mres) mstack.push_back(mseg);
                    ph = 4;
                end
                4: ph = 0;
                10: begin
                    if (mstack.size() > 0) mpop = mstack.pop_back();
                    else mpop = '0;
                    ph = 11;
                end
                default: ph = 0;
            endcase
        end
    end

    // Compare every output against the model away from the rising edge.
    always @(negedge clk) begin
        int  va;
        bit  e_push;
        va = vec_of(mt);
        if (ph == 99) begin
            chk("R1", "strobes", {mem_rd, stk_push, stk_pop, pc_load, seg_load,
                irq_ack, rti_ack}, 0);
        end else begin
            chk(ph == 1 ? "R2" : "R3", "mem_rd", mem_rd, (ph == 1 || ph == 2));
            if (ph == 1) chk("R2", "mem_addr", mem_addr, va);
            if (ph == 2) chk("R3", "mem_addr", mem_addr, va + 1);
            e_push = (ph == 3) && mmed && !mres;
            chk(mres ? "R11" : "R6", "stk_push", stk_push, e_push);
            if (e_push) chk("R6", "stk_wdata", stk_wdata, mseg);
            chk("R4", "pc_load", pc_load, ph == 4);
            if (ph == 4) begin
                chk("R4", "pc_value", pc_value,
                    {rom_byte(va + 1), rom_byte(va)});
                chk("R5", "seg_value", seg_value, 0);
            end
            chk("R7", "stk_pop", stk_pop, ph == 10);
            chk("R7", "seg_load", seg_load, (ph == 4) || (ph == 11 && mmed));
            if (ph == 11 && mmed) chk("R7", "seg_value", seg_value, mpop);
            chk(mres ? "R11" : "R8", "irq_ack", irq_ack, (ph == 4) && !mres);
            chk("R7", "rti_ack", rti_ack, ph == 11);
        end
    end

    task automatic do_irq(input int t, input bit med, input logic [1:0] seg);
        @(negedge clk);
        irq_req = 1; irq_type = 5'(t); medium_model = med; cur_seg = seg;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (irq_ack) break;
        end
        irq_req = 0;
    endtask

    task automatic do_rti(input bit med);
        @(negedge clk);
        rti_req = 1; medium_model = med;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rti_ack) break;
        end
        rti_req = 0;
    endtask

    initial begin
        int seen;
        int irq_at;
        int rti_at;
        repeat (3) @(negedge clk);
        rst_n = 1;                       // R11 boot fetch follows
        repeat (8) @(negedge clk);
        do_irq(5, 0, 2'd1);
        do_irq(22, 1, 2'd1);             // lower window top
        do_irq(23, 1, 2'd2);             // upper window start
        do_irq(27, 0, 2'd3);             // upper window end
        do_rti(1);                       // pops 2
        do_rti(0);                       // small model: no segment load
        do_rti(1);                       // pops 1
        do_rti(1);                       // empty stack
        // R10: out-of-range types are never accepted
        seen = 0;
        @(negedge clk);
        irq_req = 1; irq_type = 5'd30;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (irq_ack || mem_rd) seen++;
        end
        irq_req = 0;
        chk("R10", "activity on type 30", seen, 0);
        // R9: interrupt wins over a simultaneous return; return waits
        irq_at = -1; rti_at = -1;
        @(negedge clk);
        irq_req = 1; irq_type = 5'd0; medium_model = 1; cur_seg = 2'd3;
        rti_req = 1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (irq_ack) begin irq_at = i; irq_req = 0; end
            if (rti_ack) begin rti_at = i; rti_req = 0; break; end
        end
        chk("R9", "irq served first", (irq_at >= 0 && rti_at > irq_at), 1);
        // R11: reset in mid-fetch restarts with the boot fetch
        @(negedge clk);
        irq_req = 1; irq_type = 5'd10; medium_model = 1;
        repeat (2) @(negedge clk);
        rst_n = 0; irq_req = 0;
        repeat (2) @(negedge clk);
        rst_n = 1;
        repeat (8) @(negedge clk);
        do_irq(1, 1, 2'd2);
        do_rti(1);
        repeat (3) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 compared, mismatched);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #200000;
        compared++;
        mismatched++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***",
                 compared, mismatched);
        $finish;
    end
endmodule